// File: doc/BRIEF.md
# Shadow-Stack Access Gate

This block sits in the execute stage between decode and the load/store unit and decides, one operation at a time, whether a memory-class operation may proceed. Each operation arrives with a tag naming its kind: an ordinary load or store, or one of the four shadow-stack kinds (push, pop-and-check, pointer read, atomic swap). The same cycle supplies the current privilege level, one shadow-stack enable bit per privilege level, whether address translation is active, and whether the translated page is marked as a shadow-stack page.

The gate gives exactly one verdict per accepted operation, one clock after it is presented. It releases the operation to the load/store unit unchanged, or reports a store access fault directly to the scoreboard, or flags a shadow-stack opcode as illegal when shadow stacks are disabled at the current level. A fault carries the transaction ID and the faulting virtual address. Several violations on the same operation still produce a single fault.

Top module: `ss_access_gate`

## Requirements
- R1: Every valid operation whose tag is load (1), store (2), push (3), pop-and-check (4), pointer read (5) or swap (6) produces exactly one of forward, fault or illegal on the clock edge after it is presented. A tag of none (0) or reserved (7), or `in_valid` low, produces no verdict.
- R2: A swap (6) issued at machine level (privilege 3) with its enable set faults and is never forwarded.
- R3: A shadow-stack operation (tags 3 to 6) below machine level (privilege 0, 1 or 2) with its enable set and translation off faults.
- R4: With translation on, a push, pop-and-check or swap aimed at a page not marked as a shadow-stack page faults.
- R5: With translation on, an ordinary load or store aimed at a shadow-stack page faults. Otherwise it is forwarded whatever the enable bits hold.
- R6: The enable bit used is `ss_en[priv]`. When that bit is clear, a shadow-stack operation raises `ill_valid` with its ID, and neither forwards nor faults.
- R7: A fault reports `flt_cause` = 7 (store access fault), the operation's ID in `flt_id`, and its virtual address in `flt_tval`.
- R8: A forwarded operation keeps its tag, ID and address unchanged, so push (3) and pop-and-check (4) stay distinct from load (1) and store (2).
- R9: When a privilege rule and a page rule are both broken, exactly one fault is reported for the operation.
- R10: A pointer read (5) is exempt from the page rule. With its enable set and no privilege violation, it is forwarded whatever the page flag holds.
- R11: While reset is asserted, and on the first cycle after it, all three verdict strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation tag (0 none, 1 load, 2 store, 3 push, 4 pop-check, 5 pointer read, 6 swap, 7 reserved) |
| in_id | input | TID_W | Transaction ID |
| in_vaddr | input | VA_W | Virtual address of the access |
| priv | input | 2 | Privilege level (0 user, 1 supervisor, 2 hypervisor, 3 machine) |
| ss_en | input | 4 | Shadow-stack enable, one bit per privilege level |
| xlat_on | input | 1 | Address translation and protection active |
| page_is_ss | input | 1 | Target page is a shadow-stack page |
| lsu_valid | output | 1 | Operation released to load/store unit |
| lsu_op | output | 3 | Released operation tag |
| lsu_id | output | TID_W | Released transaction ID |
| lsu_vaddr | output | VA_W | Released address |
| flt_valid | output | 1 | Store access fault to scoreboard |
| flt_cause | output | 5 | Fault cause code |
| flt_id | output | TID_W | Faulting transaction ID |
| flt_tval | output | VA_W | Trap value (faulting address) |
| ill_valid | output | 1 | Shadow-stack opcode illegal at this level |
| ill_id | output | TID_W | Transaction ID of illegal operation |

## Verification
A wrong verdict shows at the ports one clock after the operation: an operation that should fault instead reaches the load/store unit, or a fault appears where a release was due. The only state is the single output register, so a corrupted value cannot persist past the next cycle. For that reason the bench compares all strobes and fields against its model on every clock. It covers every combination of tag, privilege, enable, translation and page flag, including the ones that break several rules at once.

// File: rtl/ss_gate_pkg.sv
package ss_gate_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_PUSH   = 3'd3,
        OP_POPCHK = 3'd4,
        OP_RDP    = 3'd5,
        OP_SWAP   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LVL_U = 2'd0,
        LVL_S = 2'd1,
        LVL_H = 2'd2,
        LVL_M = 2'd3
    } lvl_e;

    localparam int unsigned CAUSE_W      = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_ACCESS = 5'd7;

    function automatic logic op_is_shadow(input logic [2:0] op);
        return (op == OP_PUSH) || (op == OP_POPCHK) ||
               (op == OP_RDP)  || (op == OP_SWAP);
    endfunction

    function automatic logic op_is_plain(input logic [2:0] op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/ss_priv_filter.sv
module ss_priv_filter
    import ss_gate_pkg::*;
#(
    parameter int unsigned LVL_N = 4
) (
    input  logic [2:0]       op,
    input  logic [1:0]       priv,
    input  logic [LVL_N-1:0] en_vec,
    input  logic             xlat_on,
    output logic             is_shadow,
    output logic             disabled,
    output logic             priv_viol
);
    logic en_here;
    logic below_m;

    always_comb begin
        is_shadow = op_is_shadow(op);
        en_here   = en_vec[priv];
        below_m   = (priv != LVL_M);
        disabled  = is_shadow && !en_here;
        priv_viol = is_shadow && en_here &&
                    (((op == OP_SWAP) && !below_m) || (below_m && !xlat_on));
    end
endmodule

// File: rtl/ss_page_filter.sv
module ss_page_filter
    import ss_gate_pkg::*;
(
    input  logic [2:0] op,
    input  logic       xlat_on,
    input  logic       page_is_ss,
    output logic       page_viol
);
    logic ss_mem;

    always_comb begin
        ss_mem    = (op == OP_PUSH) || (op == OP_POPCHK) || (op == OP_SWAP);
        page_viol = xlat_on &&
                    ((ss_mem && !page_is_ss) || (op_is_plain(op) && page_is_ss));
    end
endmodule

// File: rtl/ss_access_gate.sv
module ss_access_gate
    import ss_gate_pkg::*;
#(
    parameter int unsigned TID_W = 4,
    parameter int unsigned VA_W  = 32,
    parameter int unsigned LVL_N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_op,
    input  logic [TID_W-1:0]    in_id,
    input  logic [VA_W-1:0]     in_vaddr,
    input  logic [1:0]          priv,
    input  logic [LVL_N-1:0]    ss_en,
    input  logic                xlat_on,
    input  logic                page_is_ss,
    output logic                lsu_valid,
    output logic [2:0]          lsu_op,
    output logic [TID_W-1:0]    lsu_id,
    output logic [VA_W-1:0]     lsu_vaddr,
    output logic                flt_valid,
    output logic [CAUSE_W-1:0]  flt_cause,
    output logic [TID_W-1:0]    flt_id,
    output logic [VA_W-1:0]     flt_tval,
    output logic                ill_valid,
    output logic [TID_W-1:0]    ill_id
);
    typedef struct packed {
        logic               fwd;
        logic               flt;
        logic               ill;
        logic [2:0]         op;
        logic [TID_W-1:0]   id;
        logic [VA_W-1:0]    addr;
    } verdict_t;

    verdict_t st_d, st_q;

    logic is_shadow, disabled, priv_viol, page_viol, known_op;

    ss_priv_filter #(.LVL_N(LVL_N)) u_priv (
        .op        (in_op),
        .priv      (priv),
        .en_vec    (ss_en),
        .xlat_on   (xlat_on),
        .is_shadow (is_shadow),
        .disabled  (disabled),
        .priv_viol (priv_viol)
    );

    ss_page_filter u_page (
        .op         (in_op),
        .xlat_on    (xlat_on),
        .page_is_ss (page_is_ss),
        .page_viol  (page_viol)
    );

    always_comb begin
        known_op = is_shadow || op_is_plain(in_op);
        st_d      = '0;
        st_d.op   = in_op;
        st_d.id   = in_id;
        st_d.addr = in_vaddr;
        if (in_valid && known_op) begin
            if (disabled) begin
                st_d.ill = 1'b1;
            end else if (priv_viol || page_viol) begin
                st_d.flt = 1'b1;
            end else begin
                st_d.fwd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lsu_valid = st_q.fwd;
    assign lsu_op    = st_q.op;
    assign lsu_id    = st_q.id;
    assign lsu_vaddr = st_q.addr;
    assign flt_valid = st_q.flt;
    assign flt_cause = st_q.flt ? CAUSE_ST_ACCESS : '0;
    assign flt_id    = st_q.id;
    assign flt_tval  = st_q.addr;
    assign ill_valid = st_q.ill;
    assign ill_id    = st_q.id;

    // R1 R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lsu_valid, flt_valid, ill_valid}) <= 1);

    // R1
    verdict_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsu_valid || flt_valid || ill_valid) |-> $past(in_valid));

    // R2
    no_m_swap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SWAP && priv == LVL_M && ss_en[priv]) |=> (flt_valid && !lsu_valid));

    // R5
    plain_on_ss_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_plain(in_op) && xlat_on && page_is_ss) |=> flt_valid);

    // R6
    disabled_is_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_shadow(in_op) && !ss_en[priv]) |=> (ill_valid && !flt_valid && !lsu_valid));

    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_cause == CAUSE_ST_ACCESS));

endmodule

// File: tb/ss_access_gate_tb.sv
module ss_access_gate_tb;
    localparam int TID_W = 4;
    localparam int VA_W  = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [2:0] in_op = 0;
    logic [TID_W-1:0] in_id = 0;
    logic [VA_W-1:0] in_vaddr = 0;
    logic [1:0] priv = 0;
    logic [3:0] ss_en = 0;
    logic xlat_on = 0;
    logic page_is_ss = 0;
    logic lsu_valid, flt_valid, ill_valid;
    logic [2:0] lsu_op;
    logic [TID_W-1:0] lsu_id, flt_id, ill_id;
    logic [VA_W-1:0] lsu_vaddr, flt_tval;
    logic [4:0] flt_cause;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected verdict: 0 none, 1 forward, 2 fault, 3 illegal
    int exp_kind = 0;
    logic [2:0] exp_op = 0;
    logic [TID_W-1:0] exp_id = 0;
    logic [VA_W-1:0] exp_addr = 0;
    string exp_tag = "R11";

    always #5 clk = ~clk;

    ss_access_gate #(.TID_W(TID_W), .VA_W(VA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_id(in_id), .in_vaddr(in_vaddr), .priv(priv), .ss_en(ss_en),
        .xlat_on(xlat_on), .page_is_ss(page_is_ss),
        .lsu_valid(lsu_valid), .lsu_op(lsu_op), .lsu_id(lsu_id), .lsu_vaddr(lsu_vaddr),
        .flt_valid(flt_valid), .flt_cause(flt_cause), .flt_id(flt_id), .flt_tval(flt_tval),
        .ill_valid(ill_valid), .ill_id(ill_id)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model: returns kind and a requirement tag that explains it
    function automatic int model(input bit v, input int op, input int pv, input bit [3:0] en,
                                 input bit xl, input bit pg, output string tag);
        bit shadow = (op >= 3 && op <= 6);
        bit plain  = (op == 1 || op == 2);
        bit pviol, gviol;
        tag = "R1";
        if (!v || !(shadow || plain)) return 0;
        if (shadow && !en[pv]) begin tag = "R6"; return 3; end
        pviol = shadow && ((op == 6 && pv == 3) || (pv != 3 && !xl));
        gviol = xl && (((op == 3 || op == 4 || op == 6) && !pg) || (plain && pg));
        if (pviol && gviol) begin tag = "R9"; return 2; end
        if (pviol) begin tag = (pv == 3) ? "R2" : "R3"; return 2; end
        if (gviol) begin tag = plain ? "R5" : "R4"; return 2; end
        tag = (op == 5) ? "R10" : (plain ? "R5" : "R8");
        return 1;
    endfunction

    task automatic compare();
        chk(lsu_valid == (exp_kind == 1), exp_tag, "lsu_valid", lsu_valid, exp_kind == 1);
        chk(flt_valid == (exp_kind == 2), exp_tag, "flt_valid", flt_valid, exp_kind == 2);
        chk(ill_valid == (exp_kind == 3), exp_tag, "ill_valid", ill_valid, exp_kind == 3);
        if (exp_kind == 1) begin
            // R8 forwarded fields unchanged
            chk(lsu_op == exp_op, "R8", "lsu_op", lsu_op, exp_op);
            chk(lsu_id == exp_id, "R8", "lsu_id", lsu_id, exp_id);
            chk(lsu_vaddr == exp_addr, "R8", "lsu_vaddr", lsu_vaddr, exp_addr);
        end
        if (exp_kind == 2) begin
            // R7 fault fields
            chk(flt_cause == 5'd7, "R7", "flt_cause", flt_cause, 7);
            chk(flt_id == exp_id, "R7", "flt_id", flt_id, exp_id);
            chk(flt_tval == exp_addr, "R7", "flt_tval", flt_tval, exp_addr);
        end
        if (exp_kind == 3)
            chk(ill_id == exp_id, "R6", "ill_id", ill_id, exp_id);
    endtask

    // At a falling edge: check the verdict of the previous operation, then drive the next
    task automatic step(input bit v, input int op, input int pv, input bit [3:0] en,
                        input bit xl, input bit pg);
        string t;
        @(negedge clk);
        compare();
        in_valid = v; in_op = op[2:0]; priv = pv[1:0]; ss_en = en;
        xlat_on = xl; page_is_ss = pg;
        in_id = in_id + 1'b1;
        in_vaddr = $urandom();
        exp_kind = model(v, op, pv, en, xl, pg, t);
        exp_tag = t;
        exp_op = op[2:0]; exp_id = in_id; exp_addr = in_vaddr;
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!lsu_valid && !flt_valid && !ill_valid, "R11", "strobes in reset",
            {lsu_valid, flt_valid, ill_valid}, 0);
        rst_n = 1;
        exp_kind = 0; exp_tag = "R11";
        // directed cases
        step(1, 6, 3, 4'hF, 0, 1);  // R2 swap in machine
        step(1, 3, 3, 4'hF, 0, 0);  // push in machine, translation off: forward
        step(1, 4, 1, 4'hF, 0, 1);  // R3 pop-check in S, translation off
        step(1, 3, 0, 4'hF, 1, 0);  // R4 push to plain page
        step(1, 4, 1, 4'hF, 1, 1);  // pop-check on ss page: forward R8
        step(1, 1, 1, 4'h0, 1, 1);  // R5 load on ss page
        step(1, 2, 0, 4'h0, 1, 0);  // R5 store plain page forward
        step(1, 3, 1, 4'b1101, 1, 1); // R6 disabled in S
        step(1, 6, 2, 4'b0100, 0, 0); // R9 swap in H, translation off: R3 rule only
        step(1, 6, 1, 4'hF, 0, 0);  // R9 no xlat: page rule not applied
        step(1, 5, 1, 4'hF, 1, 0);  // R10 pointer read on plain page
        step(1, 5, 3, 4'hF, 0, 0);  // R10 pointer read in machine
        step(1, 6, 3, 4'hF, 1, 0);  // R9 swap in M, translation on, plain page
        step(1, 0, 1, 4'hF, 1, 1);  // R1 none tag
        step(1, 7, 1, 4'hF, 1, 1);  // R1 reserved tag
        step(0, 3, 1, 4'hF, 1, 1);  // R1 no valid
        // exhaustive sweep
        for (int op = 0; op < 8; op++)
            for (int pv = 0; pv < 4; pv++)
                for (int e = 0; e < 2; e++)
                    for (int xl = 0; xl < 2; xl++)
                        for (int pg = 0; pg < 2; pg++)
                            step(1, op, pv, e ? 4'hF : (4'hF ^ (4'h1 << pv)), xl[0], pg[0]);
        // random mix
        for (int i = 0; i < 300; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
                 4'($urandom()), 1'($urandom()), 1'($urandom()));
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule